// File: doc/BRIEF.md
# Band offset pixel filter

This block corrects reconstructed video samples on the fly by adding a small signed offset to samples that fall into a chosen group of intensity bands. The sample range of every supported depth (8, 10 or 12 bits) is cut into 32 equal bands, and the band of a sample is given by its five most significant bits at that depth. A window of four neighbouring bands, whose first band is programmable and which wraps from band 31 back to band 0, receives offsets. Each of the four bands has its own signed offset. Samples in any other band leave unchanged. Every result is clipped to the legal range for the current depth.

Configuration is captured once per block of pixels on a load strobe: the first band of the window, four 16-bit signed offsets and a depth code. Samples then stream in one per cycle on a valid/ready handshake, with a flag that marks the last sample of each row. Blocks are 8, 16, 32, 48 or 64 samples wide, with any number of rows sent top to bottom. The corrected samples leave on a second valid/ready stream two cycles after they are accepted. Any backpressure on the output stalls the whole pipeline.

Top module: `band_offset_filter`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: The depth code selects the depth (0 = 8 bits, 1 = 10 bits, 2 = 12 bits, 3 behaves as 12 bits), and the band of a sample is the sample shifted right by depth minus 5, so it lies in 0..31.
- R3: The window holds the bands start, start+1, start+2 and start+3, each taken modulo 32, so a window that starts at 30 covers bands 30, 31, 0 and 1.
- R4: A sample whose band lies at position k (0..3) of the window gets the signed offset held in cfg_offsets[16k+15:16k] added to it.
- R5: A sample whose band lies outside the window leaves the block unchanged.
- R6: Each result is clipped to the range 0 to 2^depth − 1.
- R7: When the output is not stalled, a sample accepted at one clock edge appears on the output after the second clock edge that follows.
- R8: While out_valid is high and out_ready is low, the output sample and flag hold steady and in_ready is low. No sample is lost, duplicated or reordered under any pattern of backpressure.
- R9: The row-end flag leaves on out_last together with the sample it arrived with.
- R10: The configuration inputs are taken only at a clock edge where cfg_load is high. Changing them at other times has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture the configuration inputs at this edge |
| cfg_start | input | 5 | First band of the offset window |
| cfg_offsets | input | 64 | Four 16-bit signed offsets, offset k in bits 16k+15:16k |
| cfg_depth | input | 2 | Depth code: 0 = 8, 1 = 10, 2 or 3 = 12 bits |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | 12 | Input sample, right aligned |
| in_last | input | 1 | Input sample ends a row |
| out_valid | output | 1 | Output sample is valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_sample | output | 12 | Corrected and clipped sample |
| out_last | output | 1 | Output sample ends a row |

## Verification
The assertions take for granted that cfg_load is raised only while the pipeline is empty, so the depth used to check the clip range matches the depth the samples in flight were processed with. They also take for granted that in_valid is low during reset. The stimulus loads each configuration only after the scoreboard has drained, holds in_valid low through reset, and sends samples that fit within the loaded depth.

// File: rtl/band_offset_filter.sv
module band_offset_filter #(
  parameter int SW = 12,
  parameter int OW = 16,
  parameter int NB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [4:0]       cfg_start,
  input  logic [NB*OW-1:0] cfg_offsets,
  input  logic [1:0]       cfg_depth,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SW-1:0]    in_sample,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SW-1:0]    out_sample,
  output logic             out_last
);
  localparam int SUMW = ((OW > SW) ? OW : SW) + 2;

  logic [4:0]       start_q;
  logic [NB*OW-1:0] offs_q;
  logic [1:0]       dep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      offs_q  <= '0;
      dep_q   <= '0;
    end else if (cfg_load) begin
      start_q <= cfg_start;
      offs_q  <= cfg_offsets;
      dep_q   <= cfg_depth;
    end
  end

  logic en;
  assign en       = !(out_valid && !out_ready);
  assign in_ready = en;

  logic [3:0] shamt;
  always_comb begin
    case (dep_q)
      2'd0:    shamt = 4'd3;
      2'd1:    shamt = 4'd5;
      default: shamt = 4'd7;
    endcase
  end

  logic [SW-1:0] shifted;
  logic [4:0]    band, rel;
  assign shifted = in_sample >> shamt;
  assign band    = shifted[4:0];
  assign rel     = band - start_q;

  logic signed [OW-1:0] add;
  always_comb begin
    add = '0;
    for (int k = 0; k < NB; k++)
      if (rel == 5'(k)) add = offs_q[k*OW +: OW];
  end

  logic signed [SUMW-1:0] sum;
  assign sum = $signed({{(SUMW-SW){1'b0}}, in_sample}) + SUMW'(add);

  logic                   v1, last1;
  logic signed [SUMW-1:0] sum1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      last1 <= 1'b0;
      sum1  <= '0;
    end else if (en) begin
      v1    <= in_valid;
      last1 <= in_last;
      sum1  <= sum;
    end
  end

  logic signed [SUMW-1:0] maxv;
  always_comb begin
    case (dep_q)
      2'd0:    maxv = SUMW'(255);
      2'd1:    maxv = SUMW'(1023);
      default: maxv = SUMW'(4095);
    endcase
  end

  logic [SW-1:0] clipped;
  always_comb begin
    if (sum1 < 0)          clipped = '0;
    else if (sum1 > maxv)  clipped = maxv[SW-1:0];
    else                   clipped = sum1[SW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_sample <= '0;
    end else if (en) begin
      out_valid  <= v1;
      out_last   <= last1;
      out_sample <= clipped;
    end
  end
endmodule

// File: rtl/band_offset_filter_chk.sv
module band_offset_filter_chk #(
  parameter int SW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_sample,
  input logic          out_last,
  input logic [1:0]    dep_q
);
  logic [SW-1:0] lim;
  assign lim = (dep_q == 2'd0) ? SW'(255) : (dep_q == 2'd1) ? SW'(1023) : SW'(4095);

  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sample) && $stable(out_last));

  a_r8_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r6_clip_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sample <= lim);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && rst_n) && in_ready |=> out_valid);
endmodule

bind band_offset_filter band_offset_filter_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
  .out_last(out_last), .dep_q(dep_q)
);

// File: tb/tb_band_offset_filter.sv
`timescale 1ns/1ps
module tb_band_offset_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_load = 0;
  logic [4:0]  cfg_start = 0;
  logic [63:0] cfg_offsets = 0;
  logic [1:0]  cfg_depth = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [11:0] in_sample = 0;
  logic        in_last = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [11:0] out_sample;
  logic        out_last;

  always #4 clk = ~clk;

  band_offset_filter dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  bit bp_mode = 0, hold = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [12:0] q_exp[$];
  string       q_tag[$];

  int m_start = 0, m_dep = 8;
  int m_off[4] = '{0, 0, 0, 0};

  function automatic logic [11:0] model(input logic [11:0] s);
    int b, k, v, mx;
    b = int'(s) >> (m_dep - 5);
    k = (b - m_start) & 31;
    v = int'(s);
    if (k < 4) v = v + m_off[k];
    mx = (1 << m_dep) - 1;
    if (v < 0) v = 0;
    if (v > mx) v = mx;
    return 12'(v);
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) out_ready = 1'b1;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = hold ? 1'b0 : (bp_mode ? lfsr[0] : 1'b1);
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) check("R8 unexpected output", 0, out_sample, -1);
        else begin
          logic [12:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(t, {out_last, out_sample} === e, {out_last, out_sample}, e);
        end
      end
    end
  end

  task automatic load(input int st, input int o0, input int o1, input int o2, input int o3, input int dep);
    @(negedge clk); #1;
    cfg_start   = 5'(st);
    cfg_offsets = {16'(o3), 16'(o2), 16'(o1), 16'(o0)};
    cfg_depth   = (dep == 8) ? 2'd0 : (dep == 10) ? 2'd1 : 2'd2;
    cfg_load    = 1;
    @(posedge clk); #1;
    cfg_load = 0;
    m_start = st; m_dep = dep;
    m_off[0] = o0; m_off[1] = o1; m_off[2] = o2; m_off[3] = o3;
  endtask

  task automatic send(input logic [11:0] s, input bit l, input string tag);
    @(negedge clk); #1;
    in_valid = 1; in_sample = s; in_last = l;
    q_exp.push_back({l, model(s)});
    q_tag.push_back(tag);
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while (q_exp.size() != 0 && n < 3000) begin @(negedge clk); n++; end
    check("R8 drain", q_exp.size() == 0, q_exp.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 out_valid", out_valid == 0, out_valid, 0);
    check("R1 in_ready", in_ready == 1, in_ready, 1);

    // 8-bit, window bands 10..13, band = s>>3
    load(10, 5, -3, 7, -9, 8);
    send(8'd80, 0, "R4 band10");
    send(8'd95, 0, "R4 band11");
    send(8'd100, 0, "R4 band12");
    send(8'd111, 0, "R4 band13");
    send(8'd79, 0, "R5 band9");
    send(8'd112, 1, "R5 band14");
    send(8'd0, 0, "R5 band0");
    send(8'd255, 1, "R5 band31");
    drain();

    // 10-bit wrapping window 30,31,0,1
    load(30, 50, 100, -20, 40, 10);
    send(10'd970, 0, "R3 band30");
    send(10'd1023, 0, "R6 band31 clip high");
    send(10'd3, 0, "R6 band0 clip low");
    send(10'd40, 0, "R3 band1");
    send(10'd64, 0, "R3 band2 outside");
    send(10'd959, 1, "R3 band29 outside");
    drain();

    // 12-bit, band = s>>7
    load(1, 32767, -32768, 1, -1, 12);
    send(12'h0FF, 0, "R2 band1 clip high");
    send(12'h100, 0, "R2 band2 clip low");
    send(12'h07F, 0, "R2 band0 outside");
    send(12'h180, 0, "R2 band3");
    send(12'h27F, 1, "R2 band4");
    drain();

    // depth code 3 behaves as 12 bits
    load(2, 9, 0, 0, 0, 12);
    @(negedge clk); #1; cfg_depth = 2'd3; cfg_load = 1;
    @(posedge clk); #1; cfg_load = 0;
    send(12'h100, 1, "R2 depth code3");
    drain();

    // R7 latency with free output
    load(0, 1, 1, 1, 1, 8);
    send(8'd5, 1, "R7 value");
    @(negedge clk);
    check("R7 not after one edge", out_valid == 0, out_valid, 0);
    @(negedge clk);
    check("R7 after two edges", out_valid == 1, out_valid, 1);
    drain();

    // R8 stall
    hold = 1;
    @(negedge clk);
    send(8'd10, 0, "R8 stalled a");
    send(8'd20, 1, "R8 stalled b");
    begin
      logic [11:0] cap;
      @(negedge clk); cap = out_sample;
      repeat (3) @(negedge clk);
      check("R8 out_valid held", out_valid == 1, out_valid, 1);
      check("R8 in_ready low", in_ready == 0, in_ready, 0);
      check("R8 sample stable", out_sample == cap, out_sample, cap);
    end
    hold = 0;
    drain();

    // R10 config inputs changed without load
    load(4, 3, 3, 3, 3, 10);
    @(negedge clk); #1;
    cfg_start = 5'd0; cfg_offsets = {4{16'd200}}; cfg_depth = 2'd0;
    send(10'd128, 0, "R10 band4 old cfg");
    send(10'd5, 1, "R10 band0 old cfg");
    drain();

    // R9 rows under random backpressure, R8 ordering
    load(17, -7, 13, -2, 25, 10);
    bp_mode = 1;
    foreach (q_tag[i]) ;
    for (int w = 0; w < 4; w++) begin
      int width;
      width = (w == 0) ? 16 : (w == 1) ? 32 : (w == 2) ? 48 : 64;
      for (int r = 0; r < 2; r++)
        for (int c = 0; c < width; c++) begin
          logic [11:0] s;
          s = 12'($urandom_range(0, 1023));
          send(s, c == width - 1, (c == width - 1) ? "R9 row end" : "R8 random stream");
        end
    end
    drain();
    bp_mode = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule